// File: doc/BRIEF.md
# Addressed Serial Command Front-End for a Dual Wiper Controller

This block accepts a four-wire serial command stream (active-low select, serial clock, data in, data out) and turns it into register transfers for two digital potentiometer channels. Each transaction opens with an identification byte. Its upper nibble is a fixed device-type code, and its lower nibble must equal four pin-strapped address inputs. Only when both nibbles match does the block accept the instruction byte that follows. That byte carries an opcode, a data-register index and a channel select.

Each channel has one volatile 8-bit wiper position register, which drives the `wiper_o` bus, and four 8-bit stored-value registers. Both kinds are plain flip-flops. The opcodes read or write either register kind over the serial link, or move a value between a channel's wiper register and one of its stored-value registers.

All serial inputs pass through synchronizers into the `clk_i` domain, and the serial clock is edge-detected there. The system clock must therefore run several times faster than the serial clock.

Top module: `potctl_serial_front`

## Requirements
- R1: After reset, `wiper_o` is 0x0000, every stored-value register reads 0x00, and `sdo_o` and `sdo_oe_o` are both 0.
- R2: The first byte after select falls is the ID byte. It is accepted only if bits 7:4 equal 4'b0101 and bits 3:0 equal the present `addr_i`. Otherwise the rest of the transaction changes no register and never raises `sdo_oe_o`.
- R3: In the second byte, bits 7:4 are the opcode, bits 3:2 are the stored-value register index, and bit 0 selects the channel (0 for channel 0 on `wiper_o[7:0]`, 1 for channel 1 on `wiper_o[15:8]`). Bit 1 is ignored.
- R4: Opcode 4'b1010 writes the third byte into the selected wiper register.
- R5: Opcode 4'b1001 shifts the selected wiper register out on `sdo_o`, MSB first, during the third byte. Each bit changes after a falling serial clock edge, and `sdo_oe_o` is 1 during that byte.
- R6: Opcode 4'b1100 writes the third byte into the indexed stored-value register. Opcode 4'b1011 shifts that register out as in R5.
- R7: Opcode 4'b1101 copies the indexed stored-value register into the channel's wiper register, with no third byte.
- R8: Opcode 4'b1110 copies the channel's wiper register into the indexed stored-value register, with no third byte.
- R9: Any other opcode changes no register and does not drive `sdo_oe_o`.
- R10: Raising select at any point returns the parser to idle. A partially shifted data byte is discarded, and the next transaction decodes normally.
- R11: `sdo_o` is 0 whenever `sdo_oe_o` is 0, and `sdo_oe_o` is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low serial select |
| sclk_i | input | 1 | Serial clock; sampled on rise, output changes on fall |
| sdi_i | input | 1 | Serial data in, MSB first |
| addr_i | input | 4 | Pin-strapped device address |
| sdo_o | output | 1 | Serial data out, 0 when not driven |
| sdo_oe_o | output | 1 | Output enable for an external tri-state buffer |
| wiper_o | output | 16 | Wiper positions, channel 1 in bits 15:8 |

## Verification
The assertions assume that the serial inputs change slowly compared with `clk_i`. Each serial clock phase, and each select-high gap, must last long enough for the synchronizers to see every edge as a separate event. The assertions also assume that `addr_i` is stable while an ID byte is being compared. The stimulus holds each serial clock phase for six system clocks and keeps select high for at least twelve clocks between transactions. It changes `addr_i` only while select is high. It samples `sdo_o` at the end of the low phase, just before the rising edge on which a receiver would capture that bit.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [3:0] OP_RD_WCR = 4'b1001;
  localparam logic [3:0] OP_WR_WCR = 4'b1010;
  localparam logic [3:0] OP_RD_DR  = 4'b1011;
  localparam logic [3:0] OP_WR_DR  = 4'b1100;
  localparam logic [3:0] OP_DR2WCR = 4'b1101;
  localparam logic [3:0] OP_WCR2DR = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_DATA, ST_RDOUT, ST_SKIP
  } state_e;
endpackage

// File: rtl/potctl_sync.sv
module potctl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/potctl_shift.sv
module potctl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_s_i,
  input  logic         sclk_s_i,
  input  logic         sdi_s_i,
  input  logic         load_req_i,
  input  logic [W-1:0] load_data_i,
  output logic         byte_done_o,
  output logic [W-1:0] rx_o,
  output logic         sdo_bit_o
);
  localparam int unsigned CW = $clog2(W);

  logic          sclk_q, rise, fall;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rx_q, tx_q, ld_q;
  logic          done_q, pend_q;

  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ld_q   <= '0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      done_q <= 1'b0;
      if (cs_s_i) begin
        cnt_q  <= '0;
        tx_q   <= '0;
        pend_q <= 1'b0;
      end else begin
        if (rise) begin
          rx_q   <= {rx_q[W-2:0], sdi_s_i};
          cnt_q  <= cnt_q + 1'b1;
          done_q <= (cnt_q == CW'(W-1));
        end
        if (load_req_i) begin
          pend_q <= 1'b1;
          ld_q   <= load_data_i;
        end
        // first falling edge after the request presents the MSB
        if (fall) begin
          if (pend_q) begin
            tx_q   <= ld_q;
            pend_q <= 1'b0;
          end else begin
            tx_q <= {tx_q[W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign byte_done_o = done_q;
  assign rx_o        = rx_q;
  assign sdo_bit_o   = tx_q[W-1];
endmodule

// File: rtl/potctl_regs.sv
module potctl_regs #(
  parameter int unsigned W    = 8,
  parameter int unsigned NPOT = 2,
  parameter int unsigned NDR  = 4,
  localparam int unsigned PW  = (NPOT > 1) ? $clog2(NPOT) : 1,
  localparam int unsigned IW  = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wcr_we_i,
  input  logic            dr_we_i,
  input  logic [PW-1:0]   pot_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    wcr_rd_o,
  output logic [W-1:0]    dr_rd_o,
  output logic [NPOT*W-1:0] wiper_o
);
  logic [W-1:0] wcr_q [NPOT];
  logic [W-1:0] dr_q  [NPOT][NDR];

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wcr_q[p] <= '0;
      else if (wcr_we_i && pot_i == PW'(p)) wcr_q[p] <= wdata_i;
    end
    for (genvar r = 0; r < NDR; r++) begin : g_dr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dr_q[p][r] <= '0;
        else if (dr_we_i && pot_i == PW'(p) && idx_i == IW'(r)) dr_q[p][r] <= wdata_i;
      end
    end
    assign wiper_o[p*W +: W] = wcr_q[p];
  end

  assign wcr_rd_o = wcr_q[pot_i];
  assign dr_rd_o  = dr_q[pot_i][idx_i];
endmodule

// File: rtl/potctl_serial_front.sv
module potctl_serial_front
  import potctl_pkg::*;
#(
  parameter logic [3:0]  DEV_TYPE    = 4'b0101,
  parameter int unsigned NPOT        = 2,
  parameter int unsigned NDR         = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   sclk_i,
  input  logic                   sdi_i,
  input  logic [3:0]             addr_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic [NPOT*BYTE_W-1:0] wiper_o
);
  localparam int unsigned PW = (NPOT > 1) ? $clog2(NPOT) : 1;
  localparam int unsigned IW = (NDR > 1) ? $clog2(NDR) : 1;

  logic cs_s, sclk_s, sdi_s;
  logic byte_done, sdo_bit, load_req;
  logic [BYTE_W-1:0] rx, load_data, wdata, wcr_rd, dr_rd;
  logic wcr_we, dr_we;
  logic [PW-1:0] sel_pot, pot_q;
  logic [IW-1:0] sel_idx, idx_q;
  logic [3:0] op_q, rx_op;
  state_e st_q;

  potctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s));
  potctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s));
  potctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i, .rst_ni, .d_i(sdi_i), .q_o(sdi_s));

  potctl_shift #(.W(BYTE_W)) u_shift (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sclk_s_i(sclk_s), .sdi_s_i(sdi_s),
    .load_req_i(load_req), .load_data_i(load_data),
    .byte_done_o(byte_done), .rx_o(rx), .sdo_bit_o(sdo_bit));

  potctl_regs #(.W(BYTE_W), .NPOT(NPOT), .NDR(NDR)) u_regs (
    .clk_i, .rst_ni,
    .wcr_we_i(wcr_we), .dr_we_i(dr_we),
    .pot_i(sel_pot), .idx_i(sel_idx), .wdata_i(wdata),
    .wcr_rd_o(wcr_rd), .dr_rd_o(dr_rd), .wiper_o(wiper_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      pot_q <= '0;
      idx_q <= '0;
    end else if (cs_s) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_q <= ST_ID;
        ST_ID: if (byte_done)
          st_q <= (rx == {DEV_TYPE, addr_i}) ? ST_INSTR : ST_SKIP;
        ST_INSTR: if (byte_done) begin
          op_q  <= rx_op;
          pot_q <= rx[PW-1:0];
          idx_q <= rx[2 +: IW];
          unique case (rx_op)
            OP_RD_WCR, OP_RD_DR: st_q <= ST_RDOUT;
            OP_WR_WCR, OP_WR_DR: st_q <= ST_DATA;
            default:             st_q <= ST_SKIP;
          endcase
        end
        ST_DATA: if (byte_done) st_q <= ST_SKIP;
        default: ;
      endcase
    end
  end

  assign rx_op   = rx[7:4];
  assign sel_pot = (st_q == ST_INSTR) ? rx[PW-1:0] : pot_q;
  assign sel_idx = (st_q == ST_INSTR) ? rx[2 +: IW] : idx_q;

  always_comb begin
    wcr_we    = 1'b0;
    dr_we     = 1'b0;
    load_req  = 1'b0;
    wdata     = rx;
    load_data = wcr_rd;
    if (byte_done && !cs_s) begin
      if (st_q == ST_DATA) begin
        wcr_we = (op_q == OP_WR_WCR);
        dr_we  = (op_q == OP_WR_DR);
      end else if (st_q == ST_INSTR) begin
        wcr_we   = (rx_op == OP_DR2WCR);
        dr_we    = (rx_op == OP_WCR2DR);
        wdata    = (rx_op == OP_DR2WCR) ? dr_rd : wcr_rd;
        load_req = (rx_op == OP_RD_WCR) || (rx_op == OP_RD_DR);
        load_data = (rx_op == OP_RD_DR) ? dr_rd : wcr_rd;
      end
    end
  end

  assign sdo_oe_o = (st_q == ST_RDOUT);
  assign sdo_o    = sdo_oe_o & sdo_bit;
endmodule

module potctl_serial_front_chk
  import potctl_pkg::*;
#(
  parameter logic [3:0]  DEV_TYPE = 4'b0101,
  parameter int unsigned WW       = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s,
  input logic          byte_done,
  input logic [7:0]    rx,
  input logic [3:0]    addr_i,
  input state_e        st_q,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic [WW-1:0] wiper_o
);
  assert_sdo_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  assert_deselect_oe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && $past(cs_s)) |-> !sdo_oe_o);

  assert_abort_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (st_q == ST_IDLE));

  assert_id_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ID && byte_done && !cs_s && rx[7:4] != DEV_TYPE) |=> (st_q != ST_INSTR));

  assert_addr_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ID && byte_done && !cs_s && rx[3:0] != addr_i) |=> (st_q != ST_INSTR));

  // R4/R7: wiper moves only from an instruction or data byte
  assert_wiper_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> ($past(st_q) == ST_INSTR || $past(st_q) == ST_DATA));
endmodule

bind potctl_serial_front potctl_serial_front_chk #(.DEV_TYPE(DEV_TYPE), .WW(NPOT*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .byte_done(byte_done), .rx(rx),
  .addr_i(addr_i), .st_q(st_q), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .wiper_o(wiper_o));

// File: tb/tb_potctl_serial_front.sv
module tb_potctl_serial_front;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [3:0] addr = 4'b1011;
  logic sdo, sdo_oe;
  logic [15:0] wiper;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$], obs_q[$];
  string tag_q[$];
  bit oe_seen;

  always #10 clk = ~clk;

  potctl_serial_front dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .addr_i(addr), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wiper_o(wiper));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] d, input int nb, output logic [7:0] q);
    q = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk) sdi = d[i];
      repeat (HALF) @(negedge clk);
      q[i] = sdo;
      if (sdo_oe) oe_seen = 1'b1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // nbytes: 2 or 3; third byte returns what was shifted out
  task automatic xfer(input logic [7:0] b0, b1, b2, input int nbytes, output logic [7:0] rd);
    logic [7:0] dummy;
    oe_seen = 1'b0;
    @(negedge clk) cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    bits(b0, 8, dummy);
    bits(b1, 8, dummy);
    rd = '0;
    if (nbytes > 2) bits(b2, 8, rd);
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [7:0] instr(input logic [3:0] op, input int idx, input int pot);
    return {op, 2'(idx), 1'b0, 1'(pot)};
  endfunction

  function automatic logic [7:0] idb();
    return {4'b0101, addr};
  endfunction

  task automatic wr(input logic [7:0] ins, input logic [7:0] d);
    logic [7:0] r;
    xfer(idb(), ins, d, 3, r);
  endtask

  task automatic rd_expect(input logic [7:0] ins, input logic [7:0] e, input string tag);
    logic [7:0] r;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    xfer(idb(), ins, 8'h00, 3, r);
    obs_q.push_back(r);
    chk({tag, " sdo_oe"}, 32'(oe_seen), 32'd1);
  endtask

  // monitor: pairs observed read bytes with expected ones
  initial forever begin
    logic [7:0] e, o;
    string t;
    wait (obs_q.size() > 0);
    o = obs_q.pop_front();
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, 32'(o), 32'(e));
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired before completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 wiper", 32'(wiper), 32'h0);
    chk("R1 sdo", 32'(sdo), 32'h0);
    chk("R1 sdo_oe", 32'(sdo_oe), 32'h0);
    rd_expect(instr(4'b1011, 3, 1), 8'h00, "R1 dr p1 i3 reset");

    // R4 wiper writes
    wr(instr(4'b1010, 0, 0), 8'hA5);
    chk("R4 wiper0", 32'(wiper), 32'h00A5);
    wr(instr(4'b1010, 2, 1), 8'h3C);
    chk("R4 wiper1", 32'(wiper), 32'h3CA5);

    // R5 reads
    rd_expect(instr(4'b1001, 0, 0), 8'hA5, "R5 read wcr0");
    rd_expect(instr(4'b1001, 1, 1), 8'h3C, "R5 read wcr1");

    // R6 stored-value writes and reads, R3 index/pot fields
    wr(instr(4'b1100, 2, 1), 8'h81);
    wr(instr(4'b1100, 3, 0), 8'h5A);
    wr(instr(4'b1100, 0, 0), 8'h17);
    rd_expect(instr(4'b1011, 2, 1), 8'h81, "R6 dr p1 i2");
    rd_expect(instr(4'b1011, 3, 0), 8'h5A, "R6 dr p0 i3");
    rd_expect(instr(4'b1011, 0, 0), 8'h17, "R3 dr p0 i0 distinct");
    rd_expect(instr(4'b1011, 2, 0), 8'h00, "R3 dr p0 i2 untouched");
    // R3 bit1 ignored
    wr(instr(4'b1010, 0, 1) | 8'h02, 8'hC3);
    chk("R3 bit1 ignored", 32'(wiper), 32'hC3A5);

    // R7 copy stored -> wiper
    xfer(idb(), instr(4'b1101, 2, 1), 8'h00, 2, r);
    chk("R7 copy dr->wcr1", 32'(wiper), 32'h81A5);

    // R8 copy wiper -> stored
    xfer(idb(), instr(4'b1110, 1, 0), 8'h00, 2, r);
    rd_expect(instr(4'b1011, 1, 0), 8'hA5, "R8 copy wcr0->dr");

    // R2 bad type code, bad address
    xfer({4'b0110, addr}, instr(4'b1010, 0, 0), 8'h11, 3, r);
    chk("R2 bad type", 32'(wiper), 32'h81A5);
    xfer({4'b0101, 4'b0011}, instr(4'b1010, 0, 0), 8'h22, 3, r);
    chk("R2 bad addr", 32'(wiper), 32'h81A5);
    xfer({4'b0101, 4'b0011}, instr(4'b1001, 0, 0), 8'h00, 3, r);
    chk("R2 no drive", 32'(oe_seen), 32'd0);
    addr = 4'b0011;
    wr(instr(4'b1010, 0, 0), 8'h66);
    chk("R2 new addr pins", 32'(wiper), 32'h8166);

    // R9 unsupported opcodes
    xfer(idb(), instr(4'b1111, 0, 0), 8'h99, 3, r);
    chk("R9 op 1111", 32'(wiper), 32'h8166);
    chk("R9 no drive", 32'(oe_seen), 32'd0);
    xfer(idb(), instr(4'b0001, 1, 1), 8'h99, 3, r);
    chk("R9 op 0001", 32'(wiper), 32'h8166);
    rd_expect(instr(4'b1011, 1, 1), 8'h00, "R9 dr p1 i1 untouched");

    // R10 abort mid data byte
    oe_seen = 1'b0;
    @(negedge clk) cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    bits(idb(), 8, r);
    bits(instr(4'b1010, 0, 1), 8, r);
    bits(8'hFF, 5, r);
    cs_ni = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 abort keeps wiper", 32'(wiper), 32'h8166);
    wr(instr(4'b1010, 0, 1), 8'h44);
    chk("R10 next txn", 32'(wiper), 32'h4466);

    // R11 idle output
    chk("R11 sdo low", 32'(sdo), 32'h0);
    chk("R11 oe low", 32'(sdo_oe), 32'h0);

    wait (obs_q.size() == 0);
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule